// File: doc/BRIEF.md
# Branch Target and Condition Unit

This unit resolves the control-flow outcome of jump, call and conditional-branch instructions for a processor with a 16-bit program address space. The fetch stage has already collected the operand bytes and supplies them with the address of the next sequential instruction. The unit decides whether the branch is taken and produces the next program counter. It also returns the carry that a compare-and-branch writes back and the decremented loop counter of the decrement-and-branch form. Return-address stacking happens elsewhere.

An instruction is presented for one cycle with `issue_i` high. The registered result appears on the following clock edge together with `done_o`. Between results the outputs hold their last values. Calls use the same target forms as the matching jumps, so they share the long and in-page absolute classes.

Top module: `bru_unit`

## Requirements
- R1: While `rst_n` is low, every output is zero.
- R2: `done_o` is high exactly in the cycle after a cycle with `issue_i` high. The outputs change only on such a result and otherwise keep their values. The class codes on `op_i` are: 0 short relative, 1 long, 2 in-page absolute, 3 indirect, 4 jump if A zero, 5 jump if A nonzero, 6 jump on carry set, 7 jump on carry clear, 8 jump on bit set, 9 jump on bit clear, 10 compare-and-branch, 11 decrement-and-branch.
- R3: Classes 0 and 4 to 11 use the relative target `next_pc_i` plus the sign-extended `rel_i`, modulo 2^16. Class 0 is always taken.
- R4: Class 1 is always taken, with target {`addr_hi_i`, `addr_lo_i`}.
- R5: Class 2 is always taken, with target {`next_pc_i[15:11]`, `page_bits_i`, `addr_lo_i`}. `page_bits_i` carries bits 7:5 of the first instruction byte, which are address bits 10:8.
- R6: Class 3 is always taken, with target `dptr_i` + `acc_i` modulo 2^16.
- R7: Class 4 is taken when `acc_i` is 0. Class 5 is taken when `acc_i` is not 0.
- R8: Class 6 and class 7 are taken when `cy_i` is 1 and 0 respectively. Class 8 and class 9 are taken when `bit_i` is 1 and 0 respectively.
- R9: Class 10 is taken when `cmp_a_i` differs from `cmp_b_i`. It sets `cy_o` to 1 when `cmp_a_i` < `cmp_b_i` unsigned and to 0 otherwise.
- R10: Class 11 gives `cnt_o` = `cnt_i` − 1, with 00h wrapping to FFh. It is taken when that result is not zero.
- R11: A branch that is not taken, including codes 12 to 15, yields `target_o` = `next_pc_i`. `cy_o` equals `cy_i` except for class 10. `cnt_o` equals `cnt_i` except for class 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| issue_i | input | 1 | Instruction present this cycle |
| op_i | input | 4 | Branch class code |
| next_pc_i | input | 16 | Address of the byte after the instruction |
| rel_i | input | 8 | Signed relative offset |
| page_bits_i | input | 3 | In-page address bits 10:8 |
| addr_hi_i | input | 8 | Long address high byte |
| addr_lo_i | input | 8 | Long or in-page address low byte |
| acc_i | input | 8 | Accumulator |
| dptr_i | input | 16 | Data pointer |
| cy_i | input | 1 | Current carry |
| bit_i | input | 1 | Tested bit value |
| cmp_a_i | input | 8 | Compare first operand |
| cmp_b_i | input | 8 | Compare second operand |
| cnt_i | input | 8 | Counter operand for decrement-and-branch |
| done_o | output | 1 | Result valid |
| taken_o | output | 1 | Branch taken |
| target_o | output | 16 | Next program counter |
| cy_o | output | 1 | Carry after the instruction |
| cnt_o | output | 8 | Counter after the instruction |

## Verification
Some properties are checked on every cycle: the one-cycle issue-to-result timing and the hold between results, the fall-through target of untaken branches, page preservation of in-page absolute targets, and the compare outcome and carry. The decrement wrap and its taken rule, and the carry pass-through for the other classes, are checked the same way. The arithmetic of the relative, long and indirect targets can only be shown by the bench's scenarios. These include backward offsets that cross zero, the largest forward and backward offsets, indirect sums that overflow, and decrements from 00h and 01h. The scenarios also cover equal compare operands and the unused class codes.

// File: rtl/bru_pkg.sv
package bru_pkg;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam int PW = 11;

  typedef enum logic [3:0] {
    BR_SHORT = 4'd0,  BR_LONG = 4'd1,  BR_PAGE = 4'd2,  BR_IND  = 4'd3,
    BR_AZ    = 4'd4,  BR_ANZ  = 4'd5,  BR_CSET = 4'd6,  BR_CCLR = 4'd7,
    BR_BSET  = 4'd8,  BR_BCLR = 4'd9,  BR_CMP  = 4'd10, BR_DEC  = 4'd11
  } br_op_t;

  function automatic logic [AW-1:0] rel_tgt(input logic [AW-1:0] npc, input logic [DW-1:0] off);
    return npc + {{(AW-DW){off[DW-1]}}, off};
  endfunction

  function automatic logic [AW-1:0] page_tgt(input logic [AW-1:0] npc, input logic [PW-DW-1:0] hi3,
                                             input logic [DW-1:0] lo);
    return {npc[AW-1:PW], hi3, lo};
  endfunction

  function automatic logic [AW-1:0] ind_tgt(input logic [AW-1:0] base, input logic [DW-1:0] ofs);
    return base + {{(AW-DW){1'b0}}, ofs};
  endfunction

  function automatic logic uses_rel(input br_op_t op);
    return (op == BR_SHORT) || ((op >= BR_AZ) && (op <= BR_DEC));
  endfunction
endpackage

// File: rtl/bru_target.sv
module bru_target
  import bru_pkg::*;
#(
  parameter int A_W = AW,
  parameter int D_W = DW
) (
  input  br_op_t           op,
  input  logic [A_W-1:0]   npc,
  input  logic [D_W-1:0]   rel,
  input  logic [2:0]       page_hi,
  input  logic [D_W-1:0]   hi,
  input  logic [D_W-1:0]   lo,
  input  logic [D_W-1:0]   acc,
  input  logic [A_W-1:0]   dptr,
  output logic [A_W-1:0]   jump_tgt,
  output logic             rel_form
);
  logic [A_W-1:0] t_rel, t_long, t_page, t_ind;

  assign t_rel  = rel_tgt(npc, rel);
  assign t_long = {hi, lo};
  assign t_page = page_tgt(npc, page_hi, lo);
  assign t_ind  = ind_tgt(dptr, acc);
  assign rel_form = uses_rel(op);

  always_comb begin
    unique case (op)
      BR_LONG: jump_tgt = t_long;
      BR_PAGE: jump_tgt = t_page;
      BR_IND:  jump_tgt = t_ind;
      default: jump_tgt = t_rel;
    endcase
  end
endmodule

// File: rtl/bru_cond.sv
module bru_cond
  import bru_pkg::*;
#(
  parameter int D_W = DW
) (
  input  br_op_t          op,
  input  logic [D_W-1:0]  acc,
  input  logic            cy,
  input  logic            tbit,
  input  logic [D_W-1:0]  cmp_a,
  input  logic [D_W-1:0]  cmp_b,
  input  logic [D_W-1:0]  cnt,
  output logic            take,
  output logic            cy_nx,
  output logic [D_W-1:0]  cnt_nx,
  output logic            cmp_lt,
  output logic            dec_nz
);
  logic            acc_zero;
  logic [D_W-1:0]  dec_val;

  assign acc_zero = (acc == '0);
  assign cmp_lt   = (cmp_a < cmp_b);
  assign dec_val  = cnt - D_W'(1);
  assign dec_nz   = (dec_val != '0);

  always_comb begin
    take   = 1'b0;
    cy_nx  = cy;
    cnt_nx = cnt;
    case (op)
      BR_SHORT, BR_LONG, BR_PAGE, BR_IND: take = 1'b1;
      BR_AZ:   take = acc_zero;
      BR_ANZ:  take = !acc_zero;
      BR_CSET: take = cy;
      BR_CCLR: take = !cy;
      BR_BSET: take = tbit;
      BR_BCLR: take = !tbit;
      BR_CMP: begin
        take  = (cmp_a != cmp_b);
        cy_nx = cmp_lt;
      end
      BR_DEC: begin
        take   = dec_nz;
        cnt_nx = dec_val;
      end
      default: take = 1'b0;
    endcase
  end
endmodule

// File: rtl/bru_unit.sv
module bru_unit
  import bru_pkg::*;
#(
  parameter int A_W = AW,
  parameter int D_W = DW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue_i,
  input  logic [3:0]      op_i,
  input  logic [A_W-1:0]  next_pc_i,
  input  logic [D_W-1:0]  rel_i,
  input  logic [2:0]      page_bits_i,
  input  logic [D_W-1:0]  addr_hi_i,
  input  logic [D_W-1:0]  addr_lo_i,
  input  logic [D_W-1:0]  acc_i,
  input  logic [A_W-1:0]  dptr_i,
  input  logic            cy_i,
  input  logic            bit_i,
  input  logic [D_W-1:0]  cmp_a_i,
  input  logic [D_W-1:0]  cmp_b_i,
  input  logic [D_W-1:0]  cnt_i,
  output logic            done_o,
  output logic            taken_o,
  output logic [A_W-1:0]  target_o,
  output logic            cy_o,
  output logic [D_W-1:0]  cnt_o
);
  br_op_t          op;
  logic [A_W-1:0]  jump_tgt;
  logic            rel_form;
  logic            cond_take;
  logic            cy_nx;
  logic [D_W-1:0]  cnt_nx;
  logic            cmp_lt;
  logic            dec_nz;
  logic [A_W-1:0]  pc_sel;

  assign op = br_op_t'(op_i);

  bru_target #(.A_W(A_W), .D_W(D_W)) u_tgt (
    .op(op), .npc(next_pc_i), .rel(rel_i), .page_hi(page_bits_i),
    .hi(addr_hi_i), .lo(addr_lo_i), .acc(acc_i), .dptr(dptr_i),
    .jump_tgt(jump_tgt), .rel_form(rel_form)
  );

  bru_cond #(.D_W(D_W)) u_cond (
    .op(op), .acc(acc_i), .cy(cy_i), .tbit(bit_i), .cmp_a(cmp_a_i),
    .cmp_b(cmp_b_i), .cnt(cnt_i), .take(cond_take), .cy_nx(cy_nx),
    .cnt_nx(cnt_nx), .cmp_lt(cmp_lt), .dec_nz(dec_nz)
  );

  assign pc_sel = cond_take ? jump_tgt : next_pc_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o   <= 1'b0;
      taken_o  <= 1'b0;
      target_o <= '0;
      cy_o     <= 1'b0;
      cnt_o    <= '0;
    end else begin
      done_o <= issue_i;
      if (issue_i) begin
        taken_o  <= cond_take;
        target_o <= pc_sel;
        cy_o     <= cy_nx;
        cnt_o    <= cnt_nx;
      end
    end
  end
endmodule

// File: rtl/bru_unit_chk.sv
module bru_unit_chk #(
  parameter int A_W = 16,
  parameter int D_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            issue_i,
  input logic [3:0]      op_i,
  input logic [A_W-1:0]  next_pc_i,
  input logic            cy_i,
  input logic [D_W-1:0]  cmp_a_i,
  input logic [D_W-1:0]  cmp_b_i,
  input logic [D_W-1:0]  cnt_i,
  input logic            done_o,
  input logic            taken_o,
  input logic [A_W-1:0]  target_o,
  input logic            cy_o,
  input logic [D_W-1:0]  cnt_o,
  input logic            rel_form
);
  // R2
  done_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o == $past(issue_i));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(issue_i) |-> ($stable(target_o) && $stable(taken_o) && $stable(cy_o) && $stable(cnt_o)));

  // R11
  fall_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !taken_o) |-> (target_o == $past(next_pc_i)));

  // R5
  page_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && $past(op_i) == 4'd2) |-> (taken_o && target_o[A_W-1:11] == $past(next_pc_i[A_W-1:11])));

  // R9
  cmp_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && $past(op_i) == 4'd10) |->
      (taken_o == ($past(cmp_a_i) != $past(cmp_b_i)) && cy_o == ($past(cmp_a_i) < $past(cmp_b_i))));

  // R10
  dec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && $past(op_i) == 4'd11) |-> (cnt_o == $past(cnt_i) - D_W'(1) && taken_o == (cnt_o != '0)));

  // R11
  carry_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && $past(op_i) != 4'd10) |-> (cy_o == $past(cy_i)));

  // R3
  rel_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && op_i >= 4'd12) |-> !rel_form);
endmodule

bind bru_unit bru_unit_chk #(.A_W(A_W), .D_W(D_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .op_i(op_i), .next_pc_i(next_pc_i),
  .cy_i(cy_i), .cmp_a_i(cmp_a_i), .cmp_b_i(cmp_b_i), .cnt_i(cnt_i),
  .done_o(done_o), .taken_o(taken_o), .target_o(target_o), .cy_o(cy_o),
  .cnt_o(cnt_o), .rel_form(rel_form)
);

// File: tb/bru_unit_tb.sv
module bru_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic issue_i = 1'b0;
  logic [3:0] op_i = '0;
  logic [15:0] next_pc_i = '0, dptr_i = '0;
  logic [7:0] rel_i = '0, addr_hi_i = '0, addr_lo_i = '0, acc_i = '0;
  logic [7:0] cmp_a_i = '0, cmp_b_i = '0, cnt_i = '0;
  logic [2:0] page_bits_i = '0;
  logic cy_i = 1'b0, bit_i = 1'b0;
  logic done_o, taken_o, cy_o;
  logic [15:0] target_o;
  logic [7:0] cnt_o;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  bru_unit u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd0: return "R3";
      4'd1: return "R4";
      4'd2: return "R5";
      4'd3: return "R6";
      4'd4, 4'd5: return "R7";
      4'd6, 4'd7, 4'd8, 4'd9: return "R8";
      4'd10: return "R9";
      4'd11: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic run(input logic [3:0] op, input logic [15:0] npc, input logic [7:0] rel,
                     input logic [2:0] pg, input logic [7:0] hi, input logic [7:0] lo,
                     input logic [7:0] acc, input logic [15:0] dp, input logic cy, input logic b,
                     input logic [7:0] ca, input logic [7:0] cb, input logic [7:0] cn);
    logic tk, ecy;
    logic [15:0] jt, et;
    logic [7:0] ecn;
    string r;
    r = req_of(op);
    ecy = cy;
    ecn = cn;
    case (op)
      4'd1: jt = {hi, lo};
      4'd2: jt = {npc[15:11], pg, lo};
      4'd3: jt = 16'(dp + 16'(acc));
      default: jt = 16'(npc + {{8{rel[7]}}, rel});
    endcase
    case (op)
      4'd0, 4'd1, 4'd2, 4'd3: tk = 1'b1;
      4'd4: tk = (acc == 0);
      4'd5: tk = (acc != 0);
      4'd6: tk = cy;
      4'd7: tk = !cy;
      4'd8: tk = b;
      4'd9: tk = !b;
      4'd10: begin tk = (ca != cb); ecy = (ca < cb); end
      4'd11: begin ecn = cn - 8'd1; tk = (ecn != 0); end
      default: tk = 1'b0;
    endcase
    et = tk ? jt : npc;
    @(negedge clk);
    issue_i = 1'b1; op_i = op; next_pc_i = npc; rel_i = rel; page_bits_i = pg;
    addr_hi_i = hi; addr_lo_i = lo; acc_i = acc; dptr_i = dp; cy_i = cy; bit_i = b;
    cmp_a_i = ca; cmp_b_i = cb; cnt_i = cn;
    @(negedge clk);
    issue_i = 1'b0;
    op_i = 4'($urandom_range(0, 15)); next_pc_i = 16'($urandom); cnt_i = 8'($urandom);
    chk("R2 done", 32'(done_o), 32'(1));
    chk({r, " taken"}, 32'(taken_o), 32'(tk));
    chk({r, " target"}, 32'(target_o), 32'(et));
    chk({r, " cy"}, 32'(cy_o), 32'(ecy));
    chk({r, " cnt"}, 32'(cnt_o), 32'(ecn));
    @(negedge clk);
    chk("R2 idle done", 32'(done_o), 32'(0));
    chk("R2 hold target", 32'(target_o), 32'(et));
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    chk("R1 done", 32'(done_o), 32'(0));
    chk("R1 target", 32'(target_o), 32'(0));
    chk("R1 cnt_cy_taken", {22'(0), cnt_o, cy_o, taken_o}, 32'(0));
    rst_n = 1'b1;
    // R3 backward wrap below zero and extreme offsets
    run(4'd0, 16'h0002, 8'hFE, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    run(4'd0, 16'h0001, 8'h80, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    run(4'd0, 16'hFFF0, 8'h7F, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R4, R5 page edge, R6 overflow
    run(4'd1, 16'h1234, 0, 0, 8'hAB, 8'hCD, 0, 0, 0, 0, 0, 0, 0);
    run(4'd2, 16'hF800, 0, 3'b101, 0, 8'h3C, 0, 0, 0, 0, 0, 0, 0);
    run(4'd3, 16'h0000, 0, 0, 0, 0, 8'hFF, 16'hFF80, 0, 0, 0, 0, 0);
    // R7 zero / nonzero
    run(4'd4, 16'h0100, 8'h10, 0, 0, 0, 8'h00, 0, 0, 0, 0, 0, 0);
    run(4'd5, 16'h0100, 8'h10, 0, 0, 0, 8'h00, 0, 0, 0, 0, 0, 0);
    // R8 carry and bit tests
    run(4'd6, 16'h0200, 8'hF0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    run(4'd9, 16'h0200, 8'hF0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    // R9 equal, less, greater
    run(4'd10, 16'h0300, 8'h05, 0, 0, 0, 0, 0, 1, 0, 8'h44, 8'h44, 0);
    run(4'd10, 16'h0300, 8'h05, 0, 0, 0, 0, 0, 0, 0, 8'h01, 8'hFF, 0);
    run(4'd10, 16'h0300, 8'h05, 0, 0, 0, 0, 0, 1, 0, 8'hFF, 8'h01, 0);
    // R10 wrap from 00h, reach zero from 01h
    run(4'd11, 16'h0400, 8'hFC, 0, 0, 0, 0, 0, 0, 0, 0, 0, 8'h00);
    run(4'd11, 16'h0400, 8'hFC, 0, 0, 0, 0, 0, 1, 0, 0, 0, 8'h01);
    // R11 unused codes
    run(4'd12, 16'h0500, 8'h22, 0, 8'h11, 8'h22, 0, 16'h1000, 1, 1, 1, 2, 8'h09);
    run(4'd15, 16'hFFFF, 8'h22, 0, 8'h11, 8'h22, 0, 16'h1000, 0, 1, 1, 2, 8'h09);
    for (int i = 0; i < 400; i++)
      run(4'($urandom_range(0, 15)), 16'($urandom), 8'($urandom), 3'($urandom), 8'($urandom),
          8'($urandom), ($urandom_range(0, 3) == 0) ? 8'h00 : 8'($urandom), 16'($urandom),
          1'($urandom), 1'($urandom), 8'($urandom_range(0, 3)), 8'($urandom_range(0, 3)),
          8'($urandom_range(0, 3)));
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule